// File: doc/BRIEF.md
# Memory Region Security Filter

This block sits in the request path between bus masters and a DRAM controller. It checks the address of each read or write against a table of programmable address windows. Each window has an inclusive lower and upper bound and four access enables: secure read, secure write, non-secure read and non-secure write. The security state of a request is taken from bit 1 of its three-bit protection field: 0 means secure and 1 means non-secure.

A background window, index 0, covers every address that no numbered window claims. When numbered windows overlap, the enabled window with the highest index decides. A permitted request is passed downstream in the same cycle. A refused request is not passed on. It is answered one cycle later with an error flag, and a refused read returns zero data.

The window table is written through a small configuration port. That port only accepts writes that carry a secure protection field.

Top module: `mem_guard`

## Requirements
- R1: After reset every numbered window is disabled and all four enables of window 0 are clear, so every request is refused with an error and nothing is forwarded.
- R2: A numbered window matches an address when the address lies between its lower and upper bound, with both bounds included.
- R3: When several enabled numbered windows match, the one with the highest index supplies the permissions.
- R4: An address that no enabled numbered window matches takes the permissions of window 0. Window 0 has no enable of its own.
- R5: The attribute word holds five bits. Bit 0 is the window enable. Bits 1 to 4 are the secure read, secure write, non-secure read and non-secure write enables. Request protection bit 1 set to 1 selects the non-secure enables and 0 selects the secure ones.
- R6: A refused write is not forwarded (fwd_valid stays low) and gets a response with rsp_err high one cycle later.
- R7: A refused read is not forwarded and gets a response one cycle later with rsp_err high and rsp_rdata zero.
- R8: A permitted request drives fwd_valid, fwd_write, fwd_addr and fwd_wdata in the same cycle. One cycle later it gets a response with rsp_err low. A read returns the mem_rdata sampled in the request cycle, and a write returns zero data.
- R9: A configuration write with cfg_prot bit 1 set to 1 changes nothing in the window table.
- R10: A numbered window whose enable bit is clear never matches, so its address range falls through to lower-indexed windows or to window 0.
- R11: A configuration write selects the window with cfg_idx (0 to NREG) and the register with cfg_field: 0 is the lower bound, 1 is the upper bound and 2 is the attribute word. Any other index or field value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_prot | input | 3 | Protection field of the configuration write; bit 1 = non-secure |
| cfg_idx | input | IDX_W | Window index, 0 to NREG |
| cfg_field | input | 2 | Register select: 0 lower bound, 1 upper bound, 2 attributes |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_prot | input | 3 | Request protection field; bit 1 = non-secure |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| fwd_valid | output | 1 | Permitted request forwarded downstream |
| fwd_write | output | 1 | Forwarded direction |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| mem_rdata | input | DATA_W | Read data returned by memory in the forwarding cycle |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | DATA_W | Read data, zero on refusal or write |

## Verification
The bench builds the filter with NREG = 4 and 16-bit address and data. With only four windows, the highest index can sit directly over lower windows, so the priority rule, the top index and the illegal index above it can all be reached with a few configuration writes. Sixteen-bit bounds let the cases just inside and just outside a window use small constants. Within these limits the bench checks overlapping windows, windows switched off after use, attempts to write the table from non-secure code, and both security states against windows that open only one of them.

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_prot,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_prot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int ATTR_W = 5;

  logic [NREG:0][ADDR_W-1:0] base_q, top_q;
  logic [NREG:0][ATTR_W-1:0] attr_q;
  logic [IDX_W-1:0]          sel;
  logic [ATTR_W-1:0]         sel_attr;
  logic                      ns, allow;
  logic                      cfg_ok;

  wire unused_prot = ^{req_prot[2], req_prot[0], cfg_prot[2], cfg_prot[0]};

  assign cfg_ok = cfg_we && !cfg_prot[1] && (int'(cfg_idx) <= NREG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      top_q  <= '0;
      attr_q <= '0;
    end else if (cfg_ok) begin
      case (cfg_field)
        2'd0:    base_q[cfg_idx] <= cfg_wdata;
        2'd1:    top_q[cfg_idx]  <= cfg_wdata;
        2'd2:    attr_q[cfg_idx] <= cfg_wdata[ATTR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 1; i <= NREG; i++)
      if (attr_q[i][0] && req_addr >= base_q[i] && req_addr <= top_q[i])
        sel = IDX_W'(i);
  end

  assign sel_attr = attr_q[sel];
  assign ns       = req_prot[1];
  assign allow    = req_write ? (ns ? sel_attr[4] : sel_attr[2])
                              : (ns ? sel_attr[3] : sel_attr[1]);

  assign fwd_valid = req_valid && allow;
  assign fwd_write = req_write;
  assign fwd_addr  = req_addr;
  assign fwd_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !allow;
      rsp_rdata <= (req_valid && allow && !req_write) ? mem_rdata : '0;
    end
  end

  assert_refused_write_errs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !fwd_valid) |=> (rsp_valid && rsp_err));

  assert_refused_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  assert_permitted_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> (rsp_valid && !rsp_err));

  assert_ns_cfg_attr_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_prot[1]) |=> $stable(attr_q));

  assert_ns_cfg_bounds_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_prot[1]) |=> ($stable(base_q) && $stable(top_q)));

  assert_bad_field_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == 2'd3) |=> ($stable(attr_q) && $stable(base_q) && $stable(top_q)));

  assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

endmodule

// File: tb/test_mem_guard.sv
module test_mem_guard;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NR = 4;
  localparam int IW = $clog2(NR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_prot = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [1:0] cfg_field = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_prot = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic fwd_valid, fwd_write;
  logic [AW-1:0] fwd_addr;
  logic [DW-1:0] fwd_wdata, mem_rdata;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;

  always #10 clk = ~clk;

  assign mem_rdata = fwd_addr ^ 16'hA5A5;

  mem_guard #(.ADDR_W(AW), .DATA_W(DW), .NREG(NR)) i_mem_guard (
    .clk, .rst_n, .cfg_we, .cfg_prot, .cfg_idx, .cfg_field, .cfg_wdata,
    .req_valid, .req_write, .req_prot, .req_addr, .req_wdata,
    .fwd_valid, .fwd_write, .fwd_addr, .fwd_wdata, .mem_rdata,
    .rsp_valid, .rsp_err, .rsp_rdata);

  int checks = 0, failures = 0;
  bit done = 0;

  logic [AW-1:0] m_base [0:NR];
  logic [AW-1:0] m_top  [0:NR];
  logic [4:0]    m_attr [0:NR];

  logic          q_err  [$];
  logic [DW-1:0] q_data [$];
  string         q_tag  [$];

  function automatic logic model_ok(input logic wr, input logic [AW-1:0] a, input logic ns);
    int s = 0;
    for (int i = 1; i <= NR; i++)
      if (m_attr[i][0] && a >= m_base[i] && a <= m_top[i]) s = i;
    return wr ? (ns ? m_attr[s][4] : m_attr[s][2]) : (ns ? m_attr[s][3] : m_attr[s][1]);
  endfunction

  task automatic cfg(input int idx, input int fld, input logic [AW-1:0] d, input logic ns);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_prot = {1'b0, ns, 1'b0};
    cfg_idx = IW'(idx); cfg_field = 2'(fld); cfg_wdata = d;
    if (!ns && idx <= NR) begin
      if (fld == 0) m_base[idx] = d;
      else if (fld == 1) m_top[idx] = d;
      else if (fld == 2) m_attr[idx] = d[4:0];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic ns, input string tag);
    logic ok;
    ok = model_ok(wr, a, ns);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_prot = {1'b0, ns, 1'b0}; req_wdata = a + 16'h0101;
    q_err.push_back(!ok);
    q_data.push_back((ok && !wr) ? (a ^ 16'hA5A5) : '0);
    q_tag.push_back(tag);
    #2;
    checks++;
    if (fwd_valid !== ok || (ok && (fwd_addr !== a || fwd_write !== wr || fwd_wdata !== a + 16'h0101))) begin
      failures++;
      $display("FAIL %s fwd: valid=%0b addr=%h expected valid=%0b addr=%h", tag, fwd_valid, fwd_addr, ok, a);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid) begin
        checks++;
        if (q_err.size() == 0) begin
          failures++;
          $display("FAIL R8 unexpected response: err=%0b expected none", rsp_err);
        end else begin
          logic e; logic [DW-1:0] d; string t;
          e = q_err.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
          if (rsp_err !== e || rsp_rdata !== d) begin
            failures++;
            $display("FAIL %s rsp: err=%0b data=%h expected err=%0b data=%h", t, rsp_err, rsp_rdata, e, d);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    for (int i = 0; i <= NR; i++) begin m_base[i] = '0; m_top[i] = '0; m_attr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    checks++;
    if (rsp_valid !== 1'b0 || fwd_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: rsp_valid=%0b fwd_valid=%0b expected 0 0", rsp_valid, fwd_valid);
    end
    access(1'b0, 16'h0100, 1'b0, "R1 secure read after reset");
    access(1'b1, 16'h0100, 1'b1, "R1 ns write after reset");
    idle(2);

    cfg(0, 2, 16'h001E, 1'b0);
    access(1'b0, 16'h0200, 1'b1, "R4 region0 open ns read");
    access(1'b1, 16'hFFFF, 1'b0, "R8 region0 secure write");

    cfg(0, 2, 16'h0000, 1'b1);
    cfg(0, 3, 16'h0000, 1'b0);
    access(1'b0, 16'h0300, 1'b1, "R9 ns cfg write ignored");

    cfg(1, 0, 16'h1000, 1'b0);
    cfg(1, 1, 16'h1FFF, 1'b0);
    cfg(1, 2, 16'h0007, 1'b0);
    access(1'b0, 16'h1000, 1'b1, "R7 ns read of secure window");
    access(1'b1, 16'h1FFF, 1'b1, "R6 ns write of secure window");
    access(1'b0, 16'h1800, 1'b0, "R5 secure read of secure window");
    access(1'b1, 16'h1234, 1'b0, "R5 secure write of secure window");
    access(1'b0, 16'h0FFF, 1'b1, "R2 below lower bound");
    access(1'b0, 16'h2000, 1'b1, "R2 above upper bound");
    idle(1);

    cfg(3, 0, 16'h1800, 1'b0);
    cfg(3, 1, 16'h18FF, 1'b0);
    cfg(3, 2, 16'h0009, 1'b0);
    access(1'b0, 16'h1850, 1'b1, "R3 higher window grants ns read");
    access(1'b0, 16'h1850, 1'b0, "R5 secure read refused in ns window");
    access(1'b1, 16'h18FF, 1'b1, "R5 ns write refused");
    access(1'b0, 16'h1900, 1'b0, "R2 falls back to window 1");

    cfg(3, 2, 16'h0008, 1'b0);
    access(1'b0, 16'h1850, 1'b1, "R10 disabled window ignored");

    cfg(2, 0, 16'h3000, 1'b0);
    cfg(2, 1, 16'h3FFF, 1'b0);
    cfg(2, 2, 16'h0019, 1'b0);
    cfg(4, 0, 16'h3400, 1'b0);
    cfg(4, 1, 16'h34FF, 1'b0);
    cfg(4, 2, 16'h0011, 1'b0);
    cfg(5, 2, 16'h001F, 1'b0);
    access(1'b0, 16'h3410, 1'b1, "R3 top window refuses ns read");
    access(1'b1, 16'h3410, 1'b1, "R3 top window allows ns write");
    access(1'b0, 16'h3500, 1'b1, "R11 window 2 outside top window");
    access(1'b0, 16'h5000, 1'b1, "R11 index above range ignored");
    idle(1);

    cfg(0, 2, 16'h0000, 1'b0);
    access(1'b0, 16'h5000, 1'b0, "R4 region0 closed");
    access(1'b1, 16'h3001, 1'b1, "R8 window 2 ns write");
    idle(4);

    checks++;
    if (q_err.size() != 0) begin
      failures++;
      $display("FAIL R8 missing responses: pending=%0d expected 0", q_err.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule